// File: doc/BRIEF.md
# Stepped triangle LFO generator

This block produces the slow modulation values used by an FM voice engine. A free-running 7-bit phase counter walks through 128 steps. Each step lasts a whole number of output samples, chosen by a 3-bit rate code. From the counter the block derives two registered outputs. The first is a triangle-shaped amplitude-modulation level. The second is a coarser phase-modulation step that moves at one quarter of the amplitude step rate. The per-operator depth scaling and the frequency lookup that use these values are outside the block.

Software changes the block through a single control byte, written on a one-cycle strobe. Bit 3 of the byte is the enable and bits 2:0 are the rate code. Turning the generator on from the off state restarts the waveform at zero. Changing the rate while it is running keeps the waveform where it is. Turning it off freezes both outputs at their last values, so modulation can still be applied from them.

The engine pulses `sample_tick` once per output sample, after the sample has been computed. An advance caused by that pulse therefore shows up at the outputs one clock later, which means it is used by the following sample. Every pin is a plain level or strobe. There is no valid/ready stream here: the outputs are held levels that the consumer may read in any cycle, and no back-pressure applies.

Top module: `lfo_stepper`

## Requirements
- R1: The phase counter has 128 values and wraps from 127 back to 0, after which the outputs repeat the same sequence.
- R2: For counter values 0 to 63, `am_level` equals twice the counter (0, 2, ..., 126). For counter values 64 to 127, `am_level` equals 126 minus twice the counter's low 6 bits, so it falls in steps of 2 back toward 0.
- R3: `pm_step` equals the counter divided by 4 (the counter shifted right by two), which gives 32 values per cycle.
- R4: When `cfg_we` is high, `cfg_data` is taken as the control byte: bit 3 set means enabled, and bits 2:0 are the rate code. Bits 7:4 are ignored. When `cfg_we` is low, the control state is unchanged.
- R5: Rate codes 0 through 7 give 108, 77, 71, 67, 62, 44, 8 and 5 sample ticks per counter step. After a restart, the first step happens on the dwell-th tick.
- R6: A write with the enable bit set while the generator is disabled clears the counter, the tick divider, `am_level` and `pm_step` to zero. A tick in that same cycle is not counted.
- R7: A write that keeps the generator enabled but changes the rate does not clear the counter or the tick divider. The count in progress continues against the new dwell. If the count has already reached or passed the new dwell minus one, the next tick steps the counter.
- R8: While disabled, ticks are ignored, and `am_level` and `pm_step` hold their last values.
- R9: Reset (`rst_n` low, asynchronous) clears the counter, the divider and both outputs, and leaves the generator disabled with rate code 0.
- R10: The outputs are registered. A counter step caused by a tick in clock cycle k is visible after that clock edge. Outside restart writes, the outputs change only on edges where `sample_tick` is high.
- R11: A write and a tick in the same cycle apply the written settings first. An enabled rate-change write counts that tick against the new dwell, and a disabling write drops the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_data | input | 8 | Control byte: bit 3 enable, bits 2:0 rate code |
| sample_tick | input | 1 | One-cycle pulse per output sample |
| am_level | output | 7 | Triangle amplitude-modulation level |
| pm_step | output | 5 | Phase-modulation step (counter / 4) |

## Verification
The bench sweeps every rate code through a full 128-step cycle and past the wrap. A wrong dwell value, a triangle that peaks at the wrong value, or a wrap to 64 instead of 0 would each show up as a wrong level on some tick. It changes the rate in the middle of a dwell, including to a dwell shorter than the count already reached. A design that cleared the divider, or that compared for equality only, would then step late or run on for a whole wrap of the divider. It also disables the generator while the triangle is on its falling half and then keeps ticking; a design that cleared the outputs or kept counting would show the wrong levels. Finally it re-enables the generator with a tick in the same cycle, so a design that kept the old phase or counted that tick would step one tick too early.

// File: rtl/lfo_pkg.sv
package lfo_pkg;

  localparam int CFG_W      = 8;
  localparam int EN_BIT     = 3;
  localparam int RSEL_W     = 3;
  localparam int DWELL_W    = 7;
  localparam int DWELL_MAX  = 108;

  typedef logic [DWELL_W-1:0] dwell_t;

  // Sample ticks per counter step for each rate code.
  function automatic dwell_t dwell_of(input logic [RSEL_W-1:0] sel);
    case (sel)
      3'd0:    dwell_of = dwell_t'(108);
      3'd1:    dwell_of = dwell_t'(77);
      3'd2:    dwell_of = dwell_t'(71);
      3'd3:    dwell_of = dwell_t'(67);
      3'd4:    dwell_of = dwell_t'(62);
      3'd5:    dwell_of = dwell_t'(44);
      3'd6:    dwell_of = dwell_t'(8);
      default: dwell_of = dwell_t'(5);
    endcase
  endfunction

endpackage

// File: rtl/lfo_ctrl.sv
module lfo_ctrl
  import lfo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             sample_tick,
  output logic             restart,
  output logic             adv,
  output dwell_t           dwell_now
);

  logic   en_q;
  dwell_t dwell_q;
  logic   wr_on;
  logic   en_next;

  assign wr_on     = cfg_we && cfg_data[EN_BIT];
  assign en_next   = cfg_we ? cfg_data[EN_BIT] : en_q;
  assign restart   = wr_on && !en_q;
  assign dwell_now = wr_on ? dwell_of(cfg_data[RSEL_W-1:0]) : dwell_q;
  assign adv       = en_next && sample_tick && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      dwell_q <= dwell_of('0);
    end else begin
      en_q    <= en_next;
      dwell_q <= dwell_now;
    end
  end

  p_enable_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (en_q == $past(cfg_data[EN_BIT])));

  p_disabled_no_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cfg_we) |-> !adv);

endmodule

// File: rtl/lfo_rate_div.sv
module lfo_rate_div
  import lfo_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   adv,
  input  dwell_t dwell,
  output logic   step
);

  dwell_t div_q;
  logic   at_end;

  // >= rather than ==: a shorter dwell loaded mid-count still ends at once.
  assign at_end = (div_q >= dwell - dwell_t'(1));
  assign step   = adv && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '0;
    else if (restart) div_q <= '0;
    else if (adv)     div_q <= at_end ? '0 : div_q + dwell_t'(1);
  end

  p_div_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(div_q) < DWELL_MAX);

  p_div_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (div_q == '0));

endmodule

// File: rtl/lfo_phase_ctr.sv
module lfo_phase_ctr #(
  parameter int CTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [CTR_W-1:0] ctr_q,
  output logic [CTR_W-1:0] ctr_inc
);

  assign ctr_inc = ctr_q + CTR_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctr_q <= '0;
    else if (restart) ctr_q <= '0;
    else if (step)    ctr_q <= ctr_inc;
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && (&ctr_q)) |=> (ctr_q == '0));

endmodule

// File: rtl/lfo_wave_map.sv
module lfo_wave_map #(
  parameter int CTR_W    = 7,
  parameter int PM_SHIFT = 2,
  localparam int PM_W    = CTR_W - PM_SHIFT,
  localparam int HALF_W  = CTR_W - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [CTR_W-1:0] ctr_q,
  input  logic [CTR_W-1:0] ctr_nxt,
  output logic [CTR_W-1:0] am_q,
  output logic [PM_W-1:0]  pm_q
);

  logic [HALF_W-1:0] fold;
  logic [CTR_W-1:0]  am_nxt;

  // Falling half: 2*(2^HALF_W-1) - 2*low = 2*~low.
  assign fold   = ctr_nxt[CTR_W-1] ? ~ctr_nxt[HALF_W-1:0] : ctr_nxt[HALF_W-1:0];
  assign am_nxt = {fold, 1'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      am_q <= '0;
      pm_q <= '0;
    end else if (restart) begin
      am_q <= '0;
      pm_q <= '0;
    end else if (step) begin
      am_q <= am_nxt;
      pm_q <= ctr_nxt[CTR_W-1:PM_SHIFT];
    end
  end

  p_am_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !am_q[0]);

  p_pm_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pm_q == ctr_q[CTR_W-1:PM_SHIFT]);

  p_am_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart && !ctr_nxt[CTR_W-1] && (ctr_nxt != '0))
      |=> (am_q == $past(am_q) + CTR_W'(2)));

endmodule

// File: rtl/lfo_stepper.sv
module lfo_stepper
  import lfo_pkg::*;
#(
  parameter int CTR_W    = 7,
  parameter int PM_SHIFT = 2,
  localparam int PM_W    = CTR_W - PM_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             sample_tick,
  output logic [CTR_W-1:0] am_level,
  output logic [PM_W-1:0]  pm_step
);

  logic             restart;
  logic             adv;
  logic             step;
  dwell_t           dwell_now;
  logic [CTR_W-1:0] ctr_q;
  logic [CTR_W-1:0] ctr_inc;

  lfo_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_data    (cfg_data),
    .sample_tick (sample_tick),
    .restart     (restart),
    .adv         (adv),
    .dwell_now   (dwell_now)
  );

  lfo_rate_div u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .adv     (adv),
    .dwell   (dwell_now),
    .step    (step)
  );

  lfo_phase_ctr #(.CTR_W(CTR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (step),
    .ctr_q   (ctr_q),
    .ctr_inc (ctr_inc)
  );

  lfo_wave_map #(.CTR_W(CTR_W), .PM_SHIFT(PM_SHIFT)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (step),
    .ctr_q   (ctr_q),
    .ctr_nxt (ctr_inc),
    .am_q    (am_level),
    .pm_q    (pm_step)
  );

  p_quiet_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_tick && !(cfg_we && cfg_data[EN_BIT]))
      |=> ($stable(am_level) && $stable(pm_step)));

  p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (am_level == '0 && pm_step == '0));

endmodule

// File: tb/lfo_stepper_tb.sv
module lfo_stepper_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_data = 8'h00;
  logic       sample_tick = 1'b0;
  logic [6:0] am_level;
  logic [4:0] pm_step;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit m_en = 1'b0;
  int m_ctr = 0;
  int m_div = 0;
  int m_dwell = 108;

  always #10 clk = ~clk;

  lfo_stepper u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_data    (cfg_data),
    .sample_tick (sample_tick),
    .am_level    (am_level),
    .pm_step     (pm_step)
  );

  function automatic int dwell_exp(input int code);
    int t [8] = '{108, 77, 71, 67, 62, 44, 8, 5};
    return t[code];
  endfunction

  function automatic int am_exp(input int c);
    return (c < 64) ? 2 * c : 126 - 2 * (c - 64);
  endfunction

  task automatic chk(input string tag);
    n_chk++;
    if (int'(am_level) != am_exp(m_ctr) || int'(pm_step) != m_ctr / 4) begin
      n_fail++;
      $display("FAIL %s am=%0d exp %0d pm=%0d exp %0d (ctr %0d)",
               tag, am_level, am_exp(m_ctr), pm_step, m_ctr / 4, m_ctr);
    end
  endtask

  // One clock: inputs driven at negedge, model updated, checked next negedge.
  task automatic cyc(input bit we, input logic [7:0] d, input bit tk, input string tag);
    bit restart;
    bit en_n;
    cfg_we = we; cfg_data = d; sample_tick = tk;
    @(posedge clk);
    restart = we && d[3] && !m_en;
    en_n = we ? d[3] : m_en;
    if (we && d[3]) m_dwell = dwell_exp(int'(d[2:0]));
    if (restart) begin
      m_ctr = 0; m_div = 0;
    end else if (en_n && tk) begin
      if (m_div >= m_dwell - 1) begin
        m_div = 0; m_ctr = (m_ctr + 1) % 128;
      end else m_div++;
    end
    m_en = en_n;
    @(negedge clk);
    cfg_we = 1'b0; sample_tick = 1'b0;
    chk(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R9 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    // R8: disabled after reset, ticks ignored
    ticks(20, "R8 ticks while disabled");
    // R4: upper bits ignored, write with enable clear does nothing
    cyc(1'b1, 8'hF7, 1'b1, "R4 enable bit clear");
    ticks(10, "R4 still disabled");

    // R1 R2 R3 R5: full sweep of each rate through one wrap
    for (int code = 7; code >= 0; code--) begin
      cyc(1'b1, 8'h00, 1'b0, "R8 disable");
      cyc(1'b1, 8'(8 + code), 1'b0, "R6 restart");
      ticks(dwell_exp(code) - 1, "R5 dwell before first step");
      ticks(1, "R5 first step on dwell tick");
      ticks(127 * dwell_exp(code) + 3, "R1 R2 R3 sweep and wrap");
    end

    // R7: 108 dwell, 50 ticks in, switch to dwell 5: next tick steps
    cyc(1'b1, 8'h00, 1'b0, "R8 disable");
    cyc(1'b1, 8'h08, 1'b0, "R6 restart");
    ticks(50, "R7 partial count");
    cyc(1'b1, 8'h0F, 1'b0, "R7 rate change no reset");
    ticks(1, "R7 overrun count steps at once");
    ticks(12, "R7 continues at new dwell");
    // R11: rate change and tick together
    cyc(1'b1, 8'h0E, 1'b1, "R11 write with tick");
    ticks(30, "R11 after change");
    // R10: idle cycles with no tick
    for (int i = 0; i < 5; i++) cyc(1'b0, 8'h00, 1'b0, "R10 no tick no change");

    // R8: freeze on falling half
    cyc(1'b1, 8'h0F, 1'b0, "R7 to fast");
    ticks(5 * 60, "R2 falling half");
    cyc(1'b1, 8'h00, 1'b1, "R11 disable drops tick");
    ticks(200, "R8 hold while disabled");
    // R6 + R11: restart with a tick in the same cycle
    cyc(1'b1, 8'h0F, 1'b1, "R6 restart with tick");
    ticks(4, "R6 tick dropped");
    ticks(1, "R6 step on dwell");

    // R9: reset mid-run
    ticks(23, "R2 run");
    rst_n = 1'b0;
    @(negedge clk);
    m_en = 1'b0; m_ctr = 0; m_div = 0; m_dwell = 108;
    chk("R9 reset mid run");
    rst_n = 1'b1;
    ticks(10, "R9 disabled after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule